// File: doc/BRIEF.md
# Centered Crop Window Calculator

This block works out where an image sensor should be cropped so that a requested output size can be produced without distortion. Given a requested width and height, it finds the largest rectangle of the same aspect ratio that fits the full sensor frame. The rectangle fills one axis completely and is centered on the other. The rectangle is then shifted by a fixed sensor origin. It reports the start and end coordinate on each axis.

A one-cycle `start` pulse, taken only while the unit is idle, captures every input. The unit then runs four divisions back to back on one shared restoring divider, which produces one quotient bit per cycle. The divisions give the two Q10 scale factors and the two candidate crop spans. A final placement step then registers the four coordinates and raises `done`.

The control machine has these states. S_IDLE waits for a start. S_SCALE_X divides the width and S_SCALE_Y divides the height. S_SPAN_X and S_SPAN_Y compute the two candidate crop spans. S_PLACE registers the result. Its transitions are:
- start-accept: S_IDLE to S_SCALE_X.
- width-scale-ready: S_SCALE_X to S_SCALE_Y.
- height-scale-ready: S_SCALE_Y to S_SPAN_X.
- span-x-ready: S_SPAN_X to S_SPAN_Y.
- span-y-ready: S_SPAN_Y to S_PLACE.
- publish: S_PLACE to S_IDLE.

Each "ready" transition is taken when the divider reports a quotient.

Top module: `crop_window_calc`

## Requirements
- R1: The frame limit is 352 wide by 288 high when `sif_sel` is 1, and 640 by 480 when it is 0. Inputs are valid from 1 up to that limit.
- R2: The horizontal scale is fx = floor(req_w·1024 / frame width). The vertical scale is fy = floor(req_h·1024 / frame height).
- R3: When fx ≥ fy (ties included), the crop width is the frame width and the crop height is floor(req_h·1024 / fx). Otherwise the crop width is floor(req_w·1024 / fy) and the crop height is the frame height.
- R4: The offset on each axis is (frame size − crop size) / 2, truncated toward zero.
- R5: The origin depends on the sensor and frequency selects. It is (277, 37) when `alt_sensor` is 1 and `freq_sel` equals 1. It is (105, 37) when `alt_sensor` is 1 and `freq_sel` has any other value. It is (320, 35) when `alt_sensor` is 0.
- R6: On each axis, start = origin + offset and end = start + crop size. All four outputs are taken modulo 2^OUT_W.
- R7: An accepted start clears `done` one edge later. `done` rises exactly 4·(DIM_W+10+1)+1 = 85 clock edges after the edge that accepted the start. While `done` is high and no new start comes, `done` and all four coordinates hold.
- R8: A start pulse during a computation is ignored. Input changes after the accepting edge are also ignored. The result and its timing follow the original request.
- R9: After reset, `done` is 0 and all four coordinates are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request pulse, taken only in S_IDLE |
| req_w | input | DIM_W | Requested output width |
| req_h | input | DIM_W | Requested output height |
| sif_sel | input | 1 | 1 selects the small frame limit |
| alt_sensor | input | 1 | 1 selects the alternate sensor origins |
| freq_sel | input | FREQ_W | Frequency setting; value 1 picks the shifted origin |
| x_start | output | OUT_W | Left coordinate of the window |
| y_start | output | OUT_W | Top coordinate of the window |
| x_end | output | OUT_W | Right coordinate of the window |
| y_end | output | OUT_W | Bottom coordinate of the window |
| done | output | 1 | Result valid; held until the next accepted start |

## Verification
With the default widths, every result is due 85 edges after the edge that samples `start`. That is four divisions of 21 edges each (load, 20 steps, hand-over) plus one placement edge. The bench drives inputs on falling edges and counts falling edges until `done` is seen. It requires exactly 86 counts, which is 85 edges after acceptance, before it compares the coordinates. It also checks that `done` falls on the first edge of a new request. Finally, it checks that a second pulse in mid-computation neither moves the completion edge nor changes the values.

// File: rtl/crop_pkg.sv
package crop_pkg;

    localparam int FRAC_BITS = 10;

    localparam int SIF_MAX_W = 352;
    localparam int SIF_MAX_H = 288;
    localparam int VGA_MAX_W = 640;
    localparam int VGA_MAX_H = 480;

    localparam int ORG_ALT_SHIFT_X = 277;
    localparam int ORG_ALT_BASE_X  = 105;
    localparam int ORG_ALT_Y       = 37;
    localparam int ORG_STD_X       = 320;
    localparam int ORG_STD_Y       = 35;
    localparam int ALT_FREQ_CODE   = 1;

    typedef enum logic [2:0] {
        S_IDLE,
        S_SCALE_X,
        S_SCALE_Y,
        S_SPAN_X,
        S_SPAN_Y,
        S_PLACE
    } crop_state_e;

endpackage

// File: rtl/crop_divider.sv
module crop_divider #(
    parameter int W = 20
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         go,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic [W-1:0] quotient,
    output logic         valid
);
    localparam int CW = $clog2(W + 1);

    logic [W:0]    rem_q;
    logic [W-1:0]  quo_q;
    logic [W-1:0]  dvs_q;
    logic [CW-1:0] cnt_q;

    logic [W:0]    rem_sh;
    logic          fits;

    always_comb begin
        rem_sh = {rem_q[W-1:0], quo_q[W-1]};
        fits   = rem_sh >= {1'b0, dvs_q};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rem_q <= '0;
            quo_q <= '0;
            dvs_q <= '0;
            cnt_q <= '0;
            valid <= 1'b0;
        end else if (go) begin
            rem_q <= '0;
            quo_q <= dividend;
            dvs_q <= divisor;
            cnt_q <= CW'(W);
            valid <= 1'b0;
        end else if (cnt_q != '0) begin
            rem_q <= fits ? (rem_sh - {1'b0, dvs_q}) : rem_sh;
            quo_q <= {quo_q[W-2:0], fits};
            cnt_q <= cnt_q - 1'b1;
            valid <= (cnt_q == CW'(1));
        end else begin
            valid <= 1'b0;
        end
    end

    assign quotient = quo_q;

endmodule

// File: rtl/crop_origin_sel.sv
module crop_origin_sel
    import crop_pkg::*;
#(
    parameter int FREQ_W = 2,
    parameter int OUT_W  = 12
) (
    input  logic              alt_sensor,
    input  logic [FREQ_W-1:0] freq_sel,
    output logic [OUT_W-1:0]  org_x,
    output logic [OUT_W-1:0]  org_y
);
    always_comb begin
        if (!alt_sensor) begin
            org_x = OUT_W'(ORG_STD_X);
            org_y = OUT_W'(ORG_STD_Y);
        end else if (freq_sel == FREQ_W'(ALT_FREQ_CODE)) begin
            org_x = OUT_W'(ORG_ALT_SHIFT_X);
            org_y = OUT_W'(ORG_ALT_Y);
        end else begin
            org_x = OUT_W'(ORG_ALT_BASE_X);
            org_y = OUT_W'(ORG_ALT_Y);
        end
    end

endmodule

// File: rtl/crop_axis.sv
module crop_axis #(
    parameter int LEN_W = 20,
    parameter int OUT_W = 12
) (
    input  logic [LEN_W-1:0] max_len,
    input  logic [LEN_W-1:0] crop_len,
    input  logic [OUT_W-1:0] origin,
    output logic [OUT_W-1:0] lo,
    output logic [OUT_W-1:0] hi
);
    localparam int SW = LEN_W + 2;

    logic signed [SW-1:0] diff;
    logic signed [SW-1:0] half;
    logic signed [SW-1:0] lo_full;
    logic signed [SW-1:0] hi_full;

    always_comb begin
        diff    = $signed({2'b00, max_len}) - $signed({2'b00, crop_len});
        // halve with truncation toward zero
        half    = (diff + $signed({{(SW-1){1'b0}}, diff[SW-1]})) >>> 1;
        lo_full = half + $signed({{(SW-OUT_W){1'b0}}, origin});
        hi_full = lo_full + $signed({2'b00, crop_len});
        lo      = lo_full[OUT_W-1:0];
        hi      = hi_full[OUT_W-1:0];
    end

endmodule

// File: rtl/crop_window_calc.sv
module crop_window_calc
    import crop_pkg::*;
#(
    parameter int DIM_W  = 10,
    parameter int FREQ_W = 2,
    parameter int OUT_W  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [DIM_W-1:0]  req_w,
    input  logic [DIM_W-1:0]  req_h,
    input  logic              sif_sel,
    input  logic              alt_sensor,
    input  logic [FREQ_W-1:0] freq_sel,
    output logic [OUT_W-1:0]  x_start,
    output logic [OUT_W-1:0]  y_start,
    output logic [OUT_W-1:0]  x_end,
    output logic [OUT_W-1:0]  y_end,
    output logic              done
);
    localparam int DVD_W = DIM_W + FRAC_BITS;

    function automatic logic [DVD_W-1:0] frame_w(input logic sif);
        return sif ? DVD_W'(SIF_MAX_W) : DVD_W'(VGA_MAX_W);
    endfunction

    function automatic logic [DVD_W-1:0] frame_h(input logic sif);
        return sif ? DVD_W'(SIF_MAX_H) : DVD_W'(VGA_MAX_H);
    endfunction

    crop_state_e state_q, state_d;

    logic [DIM_W-1:0]  w_q, h_q;
    logic              sif_q, alt_q;
    logic [FREQ_W-1:0] freq_q;
    logic [DVD_W-1:0]  fx_q, fy_q, span_x_q, span_y_q;

    logic              div_go, div_valid;
    logic [DVD_W-1:0]  div_dvd, div_dvs, div_q;
    logic              accept;

    assign accept = (state_q == S_IDLE) && start;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // next state and divider launch
    always_comb begin
        state_d = state_q;
        div_go  = 1'b0;
        div_dvd = '0;
        div_dvs = '0;
        unique case (state_q)
            S_IDLE: begin
                div_dvd = {req_w, {FRAC_BITS{1'b0}}};
                div_dvs = frame_w(sif_sel);
                if (start) begin
                    div_go  = 1'b1;
                    state_d = S_SCALE_X;
                end
            end
            S_SCALE_X: begin
                div_dvd = {h_q, {FRAC_BITS{1'b0}}};
                div_dvs = frame_h(sif_q);
                if (div_valid) begin
                    div_go  = 1'b1;
                    state_d = S_SCALE_Y;
                end
            end
            S_SCALE_Y: begin
                div_dvd = {w_q, {FRAC_BITS{1'b0}}};
                div_dvs = div_q;
                if (div_valid) begin
                    div_go  = 1'b1;
                    state_d = S_SPAN_X;
                end
            end
            S_SPAN_X: begin
                div_dvd = {h_q, {FRAC_BITS{1'b0}}};
                div_dvs = fx_q;
                if (div_valid) begin
                    div_go  = 1'b1;
                    state_d = S_SPAN_Y;
                end
            end
            S_SPAN_Y: begin
                if (div_valid) state_d = S_PLACE;
            end
            S_PLACE: begin
                state_d = S_IDLE;
            end
            default: begin
                state_d = S_IDLE;
            end
        endcase
    end

    crop_divider #(.W(DVD_W)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .go       (div_go),
        .dividend (div_dvd),
        .divisor  (div_dvs),
        .quotient (div_q),
        .valid    (div_valid)
    );

    logic [OUT_W-1:0] org_x, org_y;

    crop_origin_sel #(.FREQ_W(FREQ_W), .OUT_W(OUT_W)) u_org (
        .alt_sensor (alt_q),
        .freq_sel   (freq_q),
        .org_x      (org_x),
        .org_y      (org_y)
    );

    logic             fill_x;
    logic [DVD_W-1:0] ax_max [2];
    logic [DVD_W-1:0] ax_len [2];
    logic [OUT_W-1:0] ax_org [2];
    logic [OUT_W-1:0] ax_lo  [2];
    logic [OUT_W-1:0] ax_hi  [2];

    always_comb begin
        fill_x    = fx_q >= fy_q;
        ax_max[0] = frame_w(sif_q);
        ax_max[1] = frame_h(sif_q);
        ax_len[0] = fill_x ? frame_w(sif_q) : span_x_q;
        ax_len[1] = fill_x ? span_y_q : frame_h(sif_q);
        ax_org[0] = org_x;
        ax_org[1] = org_y;
    end

    for (genvar a = 0; a < 2; a++) begin : g_axis
        crop_axis #(.LEN_W(DVD_W), .OUT_W(OUT_W)) u_axis (
            .max_len  (ax_max[a]),
            .crop_len (ax_len[a]),
            .origin   (ax_org[a]),
            .lo       (ax_lo[a]),
            .hi       (ax_hi[a])
        );
    end

    // captured request, quotients and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            w_q      <= '0;
            h_q      <= '0;
            sif_q    <= 1'b0;
            alt_q    <= 1'b0;
            freq_q   <= '0;
            fx_q     <= '0;
            fy_q     <= '0;
            span_x_q <= '0;
            span_y_q <= '0;
            x_start  <= '0;
            y_start  <= '0;
            x_end    <= '0;
            y_end    <= '0;
            done     <= 1'b0;
        end else begin
            if (accept) begin
                w_q    <= req_w;
                h_q    <= req_h;
                sif_q  <= sif_sel;
                alt_q  <= alt_sensor;
                freq_q <= freq_sel;
                done   <= 1'b0;
            end
            case (state_q)
                S_SCALE_X: if (div_valid) fx_q     <= div_q;
                S_SCALE_Y: if (div_valid) fy_q     <= div_q;
                S_SPAN_X:  if (div_valid) span_x_q <= div_q;
                S_SPAN_Y:  if (div_valid) span_y_q <= div_q;
                S_PLACE: begin
                    x_start <= ax_lo[0];
                    x_end   <= ax_hi[0];
                    y_start <= ax_lo[1];
                    y_end   <= ax_hi[1];
                    done    <= 1'b1;
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/crop_window_chk.sv
module crop_window_chk #(
    parameter int DIM_W  = 10,
    parameter int FREQ_W = 2,
    parameter int OUT_W  = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              sif_sel,
    input logic              alt_sensor,
    input logic [FREQ_W-1:0] freq_sel,
    input logic [OUT_W-1:0]  x_start,
    input logic [OUT_W-1:0]  y_start,
    input logic [OUT_W-1:0]  x_end,
    input logic [OUT_W-1:0]  y_end,
    input logic              done
);
    localparam int LAT = 4 * (DIM_W + 10 + 1) + 1;

    logic        run_q;
    logic        sif_c, alt_c;
    logic [FREQ_W-1:0] freq_c;
    logic [15:0] cnt_q;
    logic        take;
    logic [OUT_W-1:0] x_floor;
    logic [OUT_W-1:0] w_limit;

    assign take = start && (!run_q || done);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q  <= 1'b0;
            cnt_q  <= '0;
            sif_c  <= 1'b0;
            alt_c  <= 1'b0;
            freq_c <= '0;
        end else if (take) begin
            run_q  <= 1'b1;
            cnt_q  <= '0;
            sif_c  <= sif_sel;
            alt_c  <= alt_sensor;
            freq_c <= freq_sel;
        end else if (run_q && !done) begin
            cnt_q  <= cnt_q + 1'b1;
        end
    end

    always_comb begin
        x_floor = !alt_c ? OUT_W'(320) : (freq_c == FREQ_W'(1)) ? OUT_W'(277) : OUT_W'(105);
        w_limit = sif_c ? OUT_W'(352) : OUT_W'(640);
    end

    // R7: accepted start drops done
    p_done_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done && start |=> !done);

    // R7: result holds while idle
    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done && !start |=> done && $stable(x_start) && $stable(y_start)
                           && $stable(x_end) && $stable(y_end));

    // R8 (and R7): a pulse in mid-run does not restart the count
    p_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> run_q && (cnt_q == 16'(LAT)));

    // R3: horizontal span never exceeds the frame width
    p_span_x_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> (OUT_W'(x_end - x_start) <= w_limit));

    // R5: left edge never lies before the selected origin
    p_origin_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> (x_start >= x_floor));

endmodule

bind crop_window_calc crop_window_chk #(
    .DIM_W(DIM_W), .FREQ_W(FREQ_W), .OUT_W(OUT_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .sif_sel    (sif_sel),
    .alt_sensor (alt_sensor),
    .freq_sel   (freq_sel),
    .x_start    (x_start),
    .y_start    (y_start),
    .x_end      (x_end),
    .y_end      (y_end),
    .done       (done)
);

// File: tb/sim_crop_window_calc.sv
module sim_crop_window_calc;
    localparam int CLK_PERIOD = 10;
    localparam int DIM_W  = 10;
    localparam int FREQ_W = 2;
    localparam int OUT_W  = 12;
    localparam int EXP_LAT = 4 * (DIM_W + 10 + 1) + 1;
    localparam int MASK = (1 << OUT_W) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [DIM_W-1:0] req_w = '0, req_h = '0;
    logic sif_sel = 1'b0, alt_sensor = 1'b0;
    logic [FREQ_W-1:0] freq_sel = '0;
    logic [OUT_W-1:0] x_start, y_start, x_end, y_end;
    logic done;

    int tests = 0;
    int fails = 0;
    bit closed = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    crop_window_calc #(.DIM_W(DIM_W), .FREQ_W(FREQ_W), .OUT_W(OUT_W)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .req_w(req_w), .req_h(req_h),
        .sif_sel(sif_sel), .alt_sensor(alt_sensor), .freq_sel(freq_sel),
        .x_start(x_start), .y_start(y_start), .x_end(x_end), .y_end(y_end),
        .done(done)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // expected window from the requirements (R1..R6)
    function automatic void model(input int w, input int h, input bit sif,
                                  input bit alt, input int fq,
                                  output int ex0, output int ey0,
                                  output int ex1, output int ey1);
        int mw, mh, fx, fy, cw, ch, ox, oy;
        mw = sif ? 352 : 640;
        mh = sif ? 288 : 480;
        fx = (w * 1024) / mw;
        fy = (h * 1024) / mh;
        if (fx >= fy) begin cw = mw; ch = (h * 1024) / fx; end
        else          begin cw = (w * 1024) / fy; ch = mh; end
        if (!alt)         begin ox = 320; oy = 35; end
        else if (fq == 1) begin ox = 277; oy = 37; end
        else              begin ox = 105; oy = 37; end
        ex0 = (ox + (mw - cw) / 2) & MASK;
        ey0 = (oy + (mh - ch) / 2) & MASK;
        ex1 = (ox + (mw - cw) / 2 + cw) & MASK;
        ey1 = (oy + (mh - ch) / 2 + ch) & MASK;
    endfunction

    // issue one request; optionally disturb it mid-run
    task automatic run_case(input int w, input int h, input bit sif, input bit alt,
                            input int fq, input bit disturb, input string req);
        int ex0, ey0, ex1, ey1, cycles;
        model(w, h, sif, alt, fq, ex0, ey0, ex1, ey1);
        @(negedge clk);
        req_w = DIM_W'(w); req_h = DIM_W'(h);
        sif_sel = sif; alt_sensor = alt; freq_sel = FREQ_W'(fq);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cycles = 1;
        check(done == 1'b0, "R7", "done after accept", int'(done), 0);
        while (!done && cycles < 400) begin
            @(negedge clk);
            cycles++;
            if (disturb && cycles == 30) begin
                req_w = DIM_W'(w / 2 + 1); req_h = DIM_W'(h / 3 + 1);
                sif_sel = ~sif; alt_sensor = ~alt; freq_sel = FREQ_W'(fq + 1);
                start = 1'b1;
            end else begin
                start = 1'b0;
            end
        end
        check(cycles - 1 == EXP_LAT, disturb ? "R8" : "R7", "latency", cycles - 1, EXP_LAT);
        check(int'(x_start) == ex0, req, "x_start", int'(x_start), ex0);
        check(int'(y_start) == ey0, req, "y_start", int'(y_start), ey0);
        check(int'(x_end) == ex1, req, "x_end", int'(x_end), ex1);
        check(int'(y_end) == ey1, req, "y_end", int'(y_end), ey1);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!closed) begin
            closed = 1'b1;
            tests++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'h5EED_C401);
        repeat (3) @(negedge clk);
        // R9: reset state
        check(done == 1'b0, "R9", "done in reset", int'(done), 0);
        check(x_start == '0 && y_start == '0 && x_end == '0 && y_end == '0,
              "R9", "coords in reset", int'(x_end), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(done == 1'b0, "R9", "done after reset", int'(done), 0);

        // R1: full frames in both limits
        run_case(640, 480, 1'b0, 1'b0, 0, 1'b0, "R1");
        run_case(352, 288, 1'b1, 1'b0, 0, 1'b0, "R1");
        // R2 / R3: tall and wide requests, and a tie
        run_case(160, 480, 1'b0, 1'b0, 0, 1'b0, "R3");
        run_case(640, 120, 1'b0, 1'b0, 0, 1'b0, "R3");
        run_case(320, 240, 1'b0, 1'b0, 0, 1'b0, "R2");
        run_case(176, 144, 1'b1, 1'b0, 0, 1'b0, "R2");
        // R4: odd difference truncation
        run_case(161, 479, 1'b0, 1'b0, 0, 1'b0, "R4");
        // R5: all origin choices
        run_case(320, 240, 1'b0, 1'b1, 1, 1'b0, "R5");
        run_case(320, 240, 1'b0, 1'b1, 0, 1'b0, "R5");
        run_case(320, 240, 1'b0, 1'b1, 3, 1'b0, "R5");
        // R6: tiny request
        run_case(1, 1, 1'b1, 1'b1, 2, 1'b0, "R6");

        // R7: hold while done and idle
        repeat (5) @(negedge clk);
        check(done == 1'b1, "R7", "done held", int'(done), 1);
        // R8: mid-run start and input changes ignored
        run_case(200, 300, 1'b0, 1'b1, 1, 1'b1, "R8");
        run_case(100, 50, 1'b1, 1'b0, 2, 1'b1, "R8");

        // random mix
        for (int i = 0; i < 60; i++) begin
            bit sif;
            int w, h;
            sif = 1'($urandom % 2);
            w = 1 + int'($urandom % (sif ? 352 : 640));
            h = 1 + int'($urandom % (sif ? 288 : 480));
            run_case(w, h, sif, 1'($urandom % 2), int'($urandom % 4), 1'($urandom % 4 == 0), "R6");
        end

        if (!closed) begin
            closed = 1'b1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule